// File: doc/BRIEF.md
# DRAM Temperature Poll Scheduler

This block reads the temperature status mode register (mode register 4) of a low-power DRAM, either at regular intervals or on demand, and keeps the most recent returned byte for software to read. The interval is counted in refresh periods. A refresh-period tick marks each period, and a 3-bit code selects a power-of-two multiple from 1 to 128. Only one rank is read per poll. The configuration selects that rank, because all devices in a package are expected to run at about the same temperature.

A poll is issued to a DRAM command arbiter as a held request. The request carries a mode-register-read opcode, the rank and the register address, and it stays asserted until the arbiter grants it. The read data comes back on a return port as a one-cycle valid pulse. A tag marks whether the returned data answers this block's own request. Every returned mode-register read overwrites the captured byte, whichever command path issued it. Only a tagged return completes a poll.

Software starts a one-shot poll by pulsing the start input. The busy output is the read-back value of the start bit. It is high while a poll is in flight and drops by itself when the poll completes.

Top module: `dram_tpoll`

## Requirements
- R1: With periodic polling enabled and period code N (0..7), a request is raised at the edge of the 2^N-th refresh tick counted after the last interval restart. A tick that arrives in the same cycle as a restart is not counted.
- R2: While `cfg_poll_en` is 0, refresh ticks never raise a request. A `sw_start` pulse still launches a poll.
- R3: A request carries opcode 3'd5 (mode register read) on `cmd_opcode` and address 8'd4 on `cmd_mr_addr`. `cmd_rank` carries the value `cfg_rank_sel` had in the launch cycle, and it holds that value until the grant even if `cfg_rank_sel` changes.
- R4: A `sw_start` pulse in an idle cycle raises `cmd_req` and `sw_busy` at the next edge. `sw_busy` stays 1 until the cycle after the tagged return, and it is 0 from then on.
- R5: Every `rd_valid` pulse loads `rd_data` into `mrr_data` at that edge, whatever the value of `rd_own`. A return with `rd_own` = 0 does not complete an outstanding poll.
- R6: `cmd_req` stays asserted until a cycle with `cmd_gnt` high, and it drops at the next edge. Each poll issues exactly one request.
- R7: The interval count restarts from zero in three cases: when `cfg_poll_en` goes from 0 to 1, when `cfg_period_code` changes value, and when a poll completes.
- R8: If the interval expires while a poll is outstanding, no second poll is queued. After completion, no request appears until a new full interval has elapsed.
- R9: A `sw_start` pulse during an outstanding poll is merged into that poll. `sw_busy` clears at its completion and no extra request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_poll_en | input | 1 | Periodic polling enable |
| cfg_period_code | input | 3 | Interval code N, interval = 2^N refresh periods |
| cfg_rank_sel | input | 2 | Rank to be polled |
| sw_start | input | 1 | One-cycle pulse: software writes 1 to the start bit |
| sw_busy | output | 1 | Start bit read-back: 1 while a poll is in flight |
| refresh_tick | input | 1 | One-cycle pulse per refresh period |
| cmd_req | output | 1 | Command request to the arbiter |
| cmd_gnt | input | 1 | Grant from the arbiter |
| cmd_opcode | output | 3 | Command opcode (mode register read) |
| cmd_rank | output | 2 | Target rank of the command |
| cmd_mr_addr | output | 8 | Mode register address |
| rd_valid | input | 1 | Mode-register read data valid pulse |
| rd_own | input | 1 | Return belongs to this block's request |
| rd_data | input | 8 | Returned mode-register byte |
| mrr_data | output | 8 | Last captured mode-register byte |

## Verification
On every cycle the assertions check the handshake and capture rules. They check that the request holds and its rank stays stable until the grant, that busy covers the whole request, that every valid pulse lands in the captured byte, that a tagged return clears busy while an untagged one does not, and that an idle, disabled block never raises a request by itself. Some behaviours need the bench's counted scenarios. These are the exact 2^N interval for every code, the restarts on enable, on a code change and on completion, the refusal to queue an expired interval, and the merging of a software start.

// File: rtl/tpoll_pkg.sv
// Package: shared types and default constants of the DRAM temperature poll
// scheduler. Assumes nothing beyond IEEE 1800-2017.
package tpoll_pkg;

    // Poll sequencer state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } poll_state_e;

    // Default command encoding for a mode register read
    localparam int          OP_W_DEF    = 3;
    localparam logic [2:0]  MRR_OP_DEF  = 3'd5;
    // Default address of the temperature status mode register
    localparam int          ADDR_W_DEF  = 8;
    localparam logic [7:0]  TEMP_MR_DEF = 8'd4;

endpackage

// File: rtl/tpoll_interval.sv
// Module: refresh-period interval counter.
// Counts refresh ticks and pulses `expire` on the 2^code-th tick after a
// restart. A restart happens when the enable rises, when the code changes or
// when `restart` (poll done) is pulsed. A tick in a restart cycle is not counted.
// Assumes refresh_tick is a single-cycle pulse.
module tpoll_interval #(
    parameter int CODE_W = 3,
    localparam int CNT_W = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic              tick,
    input  logic              restart,
    output logic              expire
);

    logic              en_prev_q;
    logic [CODE_W-1:0] code_prev_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  last_val;
    logic              clear;

    // Terminal count: 2^code - 1, i.e. ones in the low `code` bits
    always_comb begin
        last_val = ~({CNT_W{1'b1}} << code);
    end

    // Restart and expiry decode
    always_comb begin
        clear  = (en && !en_prev_q) || (code != code_prev_q) || restart;
        expire = en && tick && !clear && (count_q == last_val);
    end

    // Track previous enable and code for restart detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev_q   <= 1'b0;
            code_prev_q <= '0;
        end else begin
            en_prev_q   <= en;
            code_prev_q <= code;
        end
    end

    // Tick counter, cleared on restart and wrapped on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (en && tick) begin
            count_q <= expire ? '0 : count_q + 1'b1;
        end
    end

endmodule

// File: rtl/tpoll_seq.sv
// Module: poll sequencer.
// Launches a poll on an interval expiry or a software start, holds the
// request until granted, then waits for the tagged read return. Triggers
// that arrive while a poll is outstanding are absorbed (no queueing).
// Assumes the arbiter returns exactly one tagged response per grant.
module tpoll_seq
    import tpoll_pkg::*;
#(
    parameter int RANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic              sw_start,
    input  logic [RANK_W-1:0] rank_in,
    input  logic              cmd_gnt,
    input  logic              rd_valid,
    input  logic              rd_own,
    output logic              cmd_req,
    output logic [RANK_W-1:0] cmd_rank,
    output logic              busy,
    output logic              done
);

    poll_state_e       state_q, state_d;
    logic [RANK_W-1:0] rank_q;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (expire || sw_start) state_d = ST_REQ;
            ST_REQ:  if (cmd_gnt)            state_d = ST_WAIT;
            ST_WAIT: if (rd_valid && rd_own) begin
                         state_d = ST_IDLE;
                         done    = 1'b1;
                     end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and rank latch at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rank_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_REQ) begin
                rank_q <= rank_in;
            end
        end
    end

    // Output decode
    always_comb begin
        cmd_req  = (state_q == ST_REQ);
        busy     = (state_q != ST_IDLE);
        cmd_rank = rank_q;
    end

endmodule

// File: rtl/tpoll_capture.sv
// Module: mode-register read data capture.
// Loads every returned mode-register byte, from any command path.
// Assumes rd_valid is a single-cycle pulse per returned byte.
module tpoll_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] data_out
);

    logic [DATA_W-1:0] data_q;

    // Hold the last returned byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_valid) begin
            data_q <= rd_data;
        end
    end

    assign data_out = data_q;

endmodule

// File: rtl/dram_tpoll.sv
// Module: DRAM temperature poll scheduler (top).
// Periodically, or on a software start, reads the temperature status mode
// register of one selected rank through a command arbiter and keeps the
// last returned byte. Assumes refresh_tick, sw_start and rd_valid are
// single-cycle pulses and the arbiter answers each grant once with rd_own.
module dram_tpoll
    import tpoll_pkg::*;
#(
    parameter int               CODE_W  = 3,
    parameter int               RANK_W  = 2,
    parameter int               DATA_W  = 8,
    parameter int               OP_W    = OP_W_DEF,
    parameter int               ADDR_W  = ADDR_W_DEF,
    parameter logic [OP_W-1:0]  MRR_OP  = MRR_OP_DEF,
    parameter logic [ADDR_W-1:0] TEMP_MR = TEMP_MR_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_poll_en,
    input  logic [CODE_W-1:0] cfg_period_code,
    input  logic [RANK_W-1:0] cfg_rank_sel,
    input  logic              sw_start,
    output logic              sw_busy,
    input  logic              refresh_tick,
    output logic              cmd_req,
    input  logic              cmd_gnt,
    output logic [OP_W-1:0]   cmd_opcode,
    output logic [RANK_W-1:0] cmd_rank,
    output logic [ADDR_W-1:0] cmd_mr_addr,
    input  logic              rd_valid,
    input  logic              rd_own,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] mrr_data
);

    logic expire;
    logic done;

    tpoll_interval #(.CODE_W(CODE_W)) u_interval (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_poll_en),
        .code    (cfg_period_code),
        .tick    (refresh_tick),
        .restart (done),
        .expire  (expire)
    );

    tpoll_seq #(.RANK_W(RANK_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .sw_start (sw_start),
        .rank_in  (cfg_rank_sel),
        .cmd_gnt  (cmd_gnt),
        .rd_valid (rd_valid),
        .rd_own   (rd_own),
        .cmd_req  (cmd_req),
        .cmd_rank (cmd_rank),
        .busy     (sw_busy),
        .done     (done)
    );

    tpoll_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .data_out (mrr_data)
    );

    // Fixed command fields of a temperature poll
    assign cmd_opcode  = MRR_OP;
    assign cmd_mr_addr = TEMP_MR;

endmodule

// File: rtl/dram_tpoll_chk.sv
// Module: assertion checker for dram_tpoll, attached by bind.
// Observes the top-level ports only.
module dram_tpoll_chk #(
    parameter int RANK_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_poll_en,
    input logic              sw_start,
    input logic              sw_busy,
    input logic              cmd_req,
    input logic              cmd_gnt,
    input logic [RANK_W-1:0] cmd_rank,
    input logic              rd_valid,
    input logic              rd_own,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] mrr_data
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_gnt |=> cmd_req); // R6

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && cmd_gnt |=> !cmd_req); // R6

    AST_RANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_gnt |=> $stable(cmd_rank)); // R3

    AST_BUSY_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> sw_busy); // R4

    AST_OWN_RETURN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_busy && !cmd_req && rd_valid && rd_own |=> !sw_busy); // R4

    AST_CAPTURE_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> mrr_data == $past(rd_data)); // R5

    AST_FOREIGN_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sw_busy && !cmd_req && rd_valid && !rd_own |=> sw_busy); // R5

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_busy && !cfg_poll_en && !sw_start |=> !cmd_req); // R2

endmodule

bind dram_tpoll dram_tpoll_chk #(.RANK_W(RANK_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_poll_en (cfg_poll_en),
    .sw_start    (sw_start),
    .sw_busy     (sw_busy),
    .cmd_req     (cmd_req),
    .cmd_gnt     (cmd_gnt),
    .cmd_rank    (cmd_rank),
    .rd_valid    (rd_valid),
    .rd_own      (rd_own),
    .rd_data     (rd_data),
    .mrr_data    (mrr_data)
);

// File: tb/test_dram_tpoll.sv
// Bench: sweeps all period codes and ranks of dram_tpoll and checks the
// handshake, capture, restart, no-queue and merge rules at the ports.
module test_dram_tpoll;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_poll_en = 1'b0;
    logic [2:0] cfg_period_code = 3'd0;
    logic [1:0] cfg_rank_sel = 2'd0;
    logic       sw_start = 1'b0;
    logic       sw_busy;
    logic       refresh_tick = 1'b0;
    logic       cmd_req;
    logic       cmd_gnt = 1'b0;
    logic [2:0] cmd_opcode;
    logic [1:0] cmd_rank;
    logic [7:0] cmd_mr_addr;
    logic       rd_valid = 1'b0;
    logic       rd_own = 1'b0;
    logic [7:0] rd_data = 8'd0;
    logic [7:0] mrr_data;

    int vectors = 0;
    int fails   = 0;

    always #4 clk = ~clk; // 125 MHz

    dram_tpoll i_dram_tpoll (
        .clk (clk), .rst_n (rst_n),
        .cfg_poll_en (cfg_poll_en), .cfg_period_code (cfg_period_code),
        .cfg_rank_sel (cfg_rank_sel), .sw_start (sw_start), .sw_busy (sw_busy),
        .refresh_tick (refresh_tick), .cmd_req (cmd_req), .cmd_gnt (cmd_gnt),
        .cmd_opcode (cmd_opcode), .cmd_rank (cmd_rank), .cmd_mr_addr (cmd_mr_addr),
        .rd_valid (rd_valid), .rd_own (rd_own), .rd_data (rd_data),
        .mrr_data (mrr_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one cycle; inputs change and outputs are sampled at negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_once();
        refresh_tick = 1'b1;
        step();
        refresh_tick = 1'b0;
    endtask

    task automatic start_once();
        sw_start = 1'b1;
        step();
        sw_start = 1'b0;
    endtask

    task automatic grant_after(input int delay);
        for (int i = 0; i < delay; i++) begin
            chk("R6 request held before grant", int'(cmd_req), 1);
            step();
        end
        cmd_gnt = 1'b1;
        step();
        cmd_gnt = 1'b0;
        chk("R6 request drops after grant", int'(cmd_req), 0);
        chk("R4 busy while waiting", int'(sw_busy), 1);
    endtask

    task automatic return_own(input logic [7:0] d);
        rd_valid = 1'b1; rd_own = 1'b1; rd_data = d;
        step();
        rd_valid = 1'b0; rd_own = 1'b0;
        chk("R4 busy clears on completion", int'(sw_busy), 0);
        chk("R5 poll data captured", int'(mrr_data), int'(d));
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        step();
        chk("reset cmd_req", int'(cmd_req), 0);
        chk("reset busy", int'(sw_busy), 0);
        chk("reset data", int'(mrr_data), 0);

        // R2: disabled, ticks do nothing
        cfg_period_code = 3'd0;
        step();
        for (int i = 0; i < 20; i++) begin
            tick_once();
            chk("R2 no auto poll when disabled", int'(cmd_req), 0);
        end

        // R3/R4/R2: software poll per rank, with enable off
        for (int r = 0; r < 4; r++) begin
            cfg_rank_sel = 2'(r);
            start_once();
            chk("R4 start raises request", int'(cmd_req), 1);
            chk("R4 start raises busy", int'(sw_busy), 1);
            chk("R3 opcode", int'(cmd_opcode), 5);
            chk("R3 register address", int'(cmd_mr_addr), 4);
            cfg_rank_sel = 2'(r + 1);
            step();
            chk("R3 rank latched at launch", int'(cmd_rank), r);
            grant_after(r);
            return_own(8'(8'h10 + r));
        end

        // R1/R7: interval of 2^N ticks for every code, restart on enable rise
        for (int n = 0; n < 8; n++) begin
            cfg_period_code = 3'(n);
            cfg_poll_en = 1'b1;
            refresh_tick = 1'b1; // counted? no: restart cycle wins
            step();
            refresh_tick = 1'b0;
            for (int i = 1; i <= (1 << n); i++) begin
                tick_once();
                if (i < (1 << n)) chk("R1 no request before interval", int'(cmd_req), 0);
                else              chk("R1 request at 2^N ticks", int'(cmd_req), 1);
            end
            grant_after(1);
            return_own(8'(8'h40 + n));
            cfg_poll_en = 1'b0;
            step();
        end

        // R7: restart on code change and on completion
        cfg_period_code = 3'd2;
        cfg_poll_en = 1'b1;
        step();
        repeat (3) tick_once();
        chk("R7 partial interval", int'(cmd_req), 0);
        cfg_period_code = 3'd1;
        step();
        tick_once();
        chk("R7 code change restarts count", int'(cmd_req), 0);
        tick_once();
        chk("R7 new interval after code change", int'(cmd_req), 1);
        grant_after(0);
        return_own(8'h77);
        tick_once();
        chk("R7 completion restarts count", int'(cmd_req), 0);
        tick_once();
        chk("R7 full interval after completion", int'(cmd_req), 1);
        grant_after(0);
        return_own(8'h78);

        // R8: expiries during an outstanding poll are not queued
        cfg_period_code = 3'd0;
        step();
        tick_once();
        chk("R8 first poll raised", int'(cmd_req), 1);
        repeat (3) tick_once();
        cmd_gnt = 1'b1;
        step();
        cmd_gnt = 1'b0;
        repeat (3) tick_once();
        chk("R8 still one poll in flight", int'(sw_busy), 1);
        return_own(8'h5C);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R8 no queued poll", int'(cmd_req), 0);
        end
        tick_once();
        chk("R8 next poll after new interval", int'(cmd_req), 1);
        grant_after(0);
        return_own(8'h5D);
        cfg_poll_en = 1'b0;
        step();

        // R5: foreign return when idle and while waiting
        rd_valid = 1'b1; rd_own = 1'b0; rd_data = 8'hA5;
        step();
        rd_valid = 1'b0;
        chk("R5 foreign data captured", int'(mrr_data), 8'hA5);
        chk("R5 foreign return leaves idle", int'(sw_busy), 0);
        chk("R5 foreign return raises nothing", int'(cmd_req), 0);
        start_once();
        grant_after(0);
        rd_valid = 1'b1; rd_own = 1'b0; rd_data = 8'h3C;
        step();
        rd_valid = 1'b0;
        chk("R5 foreign data during wait", int'(mrr_data), 8'h3C);
        chk("R5 foreign return does not complete", int'(sw_busy), 1);

        // R9: software start merged into outstanding poll
        start_once();
        chk("R9 busy during merged start", int'(sw_busy), 1);
        chk("R9 no new request while waiting", int'(cmd_req), 0);
        return_own(8'hC3);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R9 no extra request after merge", int'(cmd_req), 0);
        end

        finish_run();
    end

endmodule